// File: doc/BRIEF.md
# Dual-Frequency Buck PWM with Blanked Overcurrent Trip

This block is the digital core of a synchronous buck converter's switching control. Every switching period it takes a duty word from an external error path. It turns that word into a high-side on-time and produces two complementary gate enables, one for the high-side switch and one for the low-side switch. A few clock cycles of dead time separate the two enables at every edge. A mode input selects normal operation or standby. In standby the period is half as long and the on-time is capped at 90% of the period.

An overcurrent comparator flag is watched only while the high-side gate is on and the blanking time after its turn-on has passed. The flag is ignored entirely in standby. A confirmed overcurrent sets a latched fault output, which is meant to shut down the other regulators. It also forces both gates low until a clear input is pulsed. The clear input stands for a supply recycle or an externally discharged soft-start node.

All timing comes from clock-frequency parameters. With the defaults (200 MHz clock, 250 kHz switching, 400 ns blanking, 4-cycle dead time, 9-bit duty word):
- the normal period is 800 cycles;
- the standby period is 400 cycles;
- the blanking window is 80 cycles.

Top module: `sync_buck_pwm`

## Requirements
- R1: The switching period is CLK_HZ/FSW_HZ cycles (800) in normal mode and half that (400) in standby, so the high-side enable rises once per period.
- R2: In normal mode the on-time is `min(duty_i,256)*P/256` cycles, truncated. The full-scale code is 256 = 100%, and larger codes clamp to 100%. The high-side enable is high for on-time minus dead time cycles per period, or for no cycles when the on-time does not exceed the dead time. At 100% it stays high without a break.
- R3: In standby (`sleep_i`=1) the on-time from R2 is limited to 90% of the standby period (360 cycles). 0% remains reachable.
- R4: `hs_en_o` and `ls_en_o` are never high together. Each enable rises only after the other has been low, and its own raw phase has been stable, for DEAD_CYC (4) cycles. At 0% the low-side enable stays high continuously.
- R5: The duty word and the mode are sampled only at the period boundary. A change in mid-period leaves the current pulse unchanged and takes effect in the next period.
- R6: While `en_i` is low, both enables are low from the next cycle on.
- R7: `oc_i` is ignored while the high-side enable is low. It is also ignored during the first BLANK_CYC (80) cycles that the high-side enable is high.
- R8: In standby, `oc_i` never sets the fault.
- R9: When `oc_i` is seen high after blanking in normal mode, `fault_o` rises and both enables are low from the next cycle. They stay that way, whatever `oc_i` does, until a clear.
- R10: A one-cycle pulse on `fault_clr_i` drops `fault_o` in the next cycle, and switching then resumes.
- R11: During reset all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable; low forces both gates off |
| sleep_i | input | 1 | 1 = standby (half period, 90% cap, no overcurrent), 0 = normal |
| duty_i | input | DUTY_W (9) | Duty word; 256 = 100% |
| oc_i | input | 1 | Overcurrent comparator flag |
| fault_clr_i | input | 1 | Clears the latched overcurrent fault |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| fault_o | output | 1 | Latched overcurrent fault |

## Verification
A wrong period count or a wrongly latched on-time shows as a wrong number of high-side or low-side cycles in any window of one period. It also shows as a wrong count of rising edges over four normal periods. Both of these appear within one to two periods of the stimulus. A blanking counter that is one short or one long shows in a single cycle, because a fault either sets or fails to set on the exact edge at which the window closes. A leak in the latch or the gating shows up as gate activity, or a dropped fault, in the first cycle after the trip or after a disable. A dead-time or overlap error shows at the very edge where one gate turns off.

// File: rtl/buck_pwm_pkg.sv
`timescale 1ns/1ps
package buck_pwm_pkg;

    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_SLEEP = 1'b1
    } pwr_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import buck_pwm_pkg::*;
#(
    parameter int P_NORM    = 800,
    parameter int P_SB      = 400,
    parameter int SB_MAX_ON = 360,
    parameter int DUTY_W    = 9,
    parameter int CNT_W     = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              sleep_i,
    output logic              raw_hi_o,
    output pwr_mode_e         mode_o
);
    localparam int FS_SHIFT = DUTY_W - 1;
    localparam int FS       = 1 << FS_SHIFT;
    localparam int PROD_W   = CNT_W + DUTY_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] on;
        pwr_mode_e        mode;
    } tb_state_t;

    tb_state_t st_d, st_q;

    logic [DUTY_W-1:0] duty_sat;
    logic [PROD_W-1:0] prod_norm, prod_sb;
    logic [CNT_W-1:0]  on_norm, on_sb, last_idx;

    always_comb begin
        st_d      = st_q;
        duty_sat  = (duty_i > DUTY_W'(FS)) ? DUTY_W'(FS) : duty_i;
        prod_norm = PROD_W'(duty_sat) * PROD_W'(P_NORM);
        prod_sb   = PROD_W'(duty_sat) * PROD_W'(P_SB);
        on_norm   = CNT_W'(prod_norm >> FS_SHIFT);
        on_sb     = CNT_W'(prod_sb >> FS_SHIFT);
        if (on_sb > CNT_W'(SB_MAX_ON)) begin
            on_sb = CNT_W'(SB_MAX_ON);
        end
        last_idx = (st_q.mode == MODE_SLEEP) ? CNT_W'(P_SB - 1) : CNT_W'(P_NORM - 1);
        if (st_q.cnt == last_idx) begin
            st_d.cnt  = '0;
            st_d.mode = sleep_i ? MODE_SLEEP : MODE_RUN;
            st_d.on   = sleep_i ? on_sb : on_norm;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, on: '0, mode: MODE_RUN};
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_hi_o = (st_q.cnt < st_q.on);
    assign mode_o   = st_q.mode;

endmodule

// File: rtl/pwm_gate_shaper.sv
`timescale 1ns/1ps
module pwm_gate_shaper
    import buck_pwm_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       raw_hi_i,
    input  logic       allow_i,
    output gate_pair_t gates_o
);
    localparam int RUN_W   = $clog2(DEAD_CYC + 2);
    localparam int RUN_TOP = DEAD_CYC + 1;

    typedef struct packed {
        logic       prev;
        logic [RUN_W-1:0] run;
        gate_pair_t gates;
    } gs_state_t;

    gs_state_t st_d, st_q;
    logic      settled;

    always_comb begin
        st_d      = st_q;
        st_d.prev = raw_hi_i;
        if (raw_hi_i != st_q.prev) begin
            st_d.run = RUN_W'(1);
        end else if (st_q.run != RUN_W'(RUN_TOP)) begin
            st_d.run = st_q.run + RUN_W'(1);
        end
        settled       = (st_d.run == RUN_W'(RUN_TOP));
        st_d.gates.hi = allow_i && raw_hi_i && settled;
        st_d.gates.lo = allow_i && !raw_hi_i && settled;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gates_o = st_q.gates;

endmodule

// File: rtl/oc_trip_latch.sv
`timescale 1ns/1ps
module oc_trip_latch
    import buck_pwm_pkg::*;
#(
    parameter int BLANK_CYC = 80
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      hi_on_i,
    input  logic      oc_i,
    input  pwr_mode_e mode_i,
    input  logic      clr_i,
    output logic      fault_q_o,
    output logic      fault_d_o
);
    localparam int BL_W = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic [BL_W-1:0] blank;
        logic            fault;
    } oc_state_t;

    oc_state_t st_d, st_q;
    logic      armed, trip;

    always_comb begin
        st_d  = st_q;
        armed = hi_on_i && (st_q.blank == BL_W'(BLANK_CYC));
        trip  = armed && oc_i && (mode_i == MODE_RUN);
        if (!hi_on_i) begin
            st_d.blank = '0;
        end else if (st_q.blank != BL_W'(BLANK_CYC)) begin
            st_d.blank = st_q.blank + BL_W'(1);
        end
        if (clr_i) begin
            st_d.fault = 1'b0;
        end else begin
            st_d.fault = st_q.fault || trip;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_q_o = st_q.fault;
    assign fault_d_o = st_d.fault;

endmodule

// File: rtl/sync_buck_pwm.sv
`timescale 1ns/1ps
module sync_buck_pwm
    import buck_pwm_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int FSW_HZ     = 250_000,
    parameter int BLANK_NS   = 400,
    parameter int DEAD_CYC   = 4,
    parameter int DUTY_W     = 9,
    parameter int SB_MAX_PCT = 90
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              sleep_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              oc_i,
    input  logic              fault_clr_i,
    output logic              hs_en_o,
    output logic              ls_en_o,
    output logic              fault_o
);
    localparam int P_NORM    = CLK_HZ / FSW_HZ;
    localparam int P_SB      = P_NORM / 2;
    localparam int SB_MAX_ON = (P_SB * SB_MAX_PCT) / 100;
    localparam int BLANK_CYC = ((CLK_HZ / 1_000_000) * BLANK_NS) / 1000;
    localparam int CNT_W     = $clog2(P_NORM + 1);

    logic       raw_hi;
    pwr_mode_e  mode_q;
    logic       sleep_q;
    gate_pair_t gates;
    logic       fault_q, fault_d, allow;

    pwm_timebase #(
        .P_NORM(P_NORM), .P_SB(P_SB), .SB_MAX_ON(SB_MAX_ON),
        .DUTY_W(DUTY_W), .CNT_W(CNT_W)
    ) u_timebase (
        .clk_i(clk_i), .rst_ni(rst_ni), .duty_i(duty_i), .sleep_i(sleep_i),
        .raw_hi_o(raw_hi), .mode_o(mode_q)
    );

    oc_trip_latch #(
        .BLANK_CYC(BLANK_CYC)
    ) u_trip (
        .clk_i(clk_i), .rst_ni(rst_ni), .hi_on_i(gates.hi), .oc_i(oc_i),
        .mode_i(mode_q), .clr_i(fault_clr_i),
        .fault_q_o(fault_q), .fault_d_o(fault_d)
    );

    assign allow = en_i && !fault_d;

    pwm_gate_shaper #(
        .DEAD_CYC(DEAD_CYC)
    ) u_shaper (
        .clk_i(clk_i), .rst_ni(rst_ni), .raw_hi_i(raw_hi), .allow_i(allow),
        .gates_o(gates)
    );

    assign sleep_q = (mode_q == MODE_SLEEP);
    assign hs_en_o = gates.hi;
    assign ls_en_o = gates.lo;
    assign fault_o = fault_q;

endmodule

// File: rtl/buck_pwm_sva.sv
`timescale 1ns/1ps
module buck_pwm_sva #(
    parameter int BLANK_CYC = 80
) (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic fault_clr_i,
    input logic hs_en_o,
    input logic ls_en_o,
    input logic fault_o,
    input logic sleep_q
);
    logic [31:0] hi_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_run <= '0;
        end else if (!hs_en_o) begin
            hi_run <= '0;
        end else if (hi_run < 32'(BLANK_CYC)) begin
            hi_run <= hi_run + 32'd1;
        end
    end

    assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hs_en_o && ls_en_o));

    assert_dead_after_hs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hs_en_o) |=> !ls_en_o);

    assert_dead_after_ls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ls_en_o) |=> !hs_en_o);

    assert_disable_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!hs_en_o && !ls_en_o));

    assert_blank_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fault_o) |-> ($past(hs_en_o) && ($past(hi_run) >= 32'(BLANK_CYC))));

    assert_sleep_no_trip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fault_o) |-> !$past(sleep_q));

    assert_fault_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (!hs_en_o && !ls_en_o));

    assert_fault_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && !fault_clr_i) |=> fault_o);

    assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_clr_i |=> !fault_o);

endmodule

bind sync_buck_pwm buck_pwm_sva #(.BLANK_CYC(BLANK_CYC)) u_sva (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .fault_clr_i(fault_clr_i),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o), .fault_o(fault_o), .sleep_q(sleep_q)
);

// File: tb/sync_buck_pwm_test.sv
`timescale 1ns/1ps
module sync_buck_pwm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       sleep = 1'b0;
    logic [8:0] duty = '0;
    logic       oc = 1'b0;
    logic       clr = 1'b0;
    logic       hs, ls, fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sync_buck_pwm uut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sleep_i(sleep), .duty_i(duty),
        .oc_i(oc), .fault_clr_i(clr), .hs_en_o(hs), .ls_en_o(ls), .fault_o(fault)
    );

    // mode, duty word, high cycles/period, low cycles/period, rises in 3200 cycles
    localparam int VEC_N = 11;
    localparam int V_SB  [VEC_N] = '{0,   0,   0,   0,   0,   1,   1,   1,   1,   0,   0};
    localparam int V_CMD [VEC_N] = '{128, 64,  256, 0,   300, 128, 256, 240, 0,   1,   2};
    localparam int V_HI  [VEC_N] = '{396, 196, 800, 0,   800, 196, 356, 356, 0,   0,   2};
    localparam int V_LO  [VEC_N] = '{396, 596, 0,   800, 0,   196, 36,  36,  400, 793, 790};
    localparam int V_RISE[VEC_N] = '{4,   4,   0,   0,   0,   8,   8,   8,   0,   0,   4};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 1'b0;
        prev = hs;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!prev && hs) begin
                ok = 1'b1;
                return;
            end
            prev = hs;
        end
    endtask

    task automatic wait_fall(output bit ok);
        logic prev;
        ok = 1'b0;
        prev = hs;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (prev && !hs) begin
                ok = 1'b1;
                return;
            end
            prev = hs;
        end
    endtask

    // Called right after wait_rise: counts the cycles of the pulse just started.
    task automatic pulse_width(output int w);
        w = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (hs) w++;
            else return;
        end
    endtask

    initial begin
        int  hi_n, lo_n, rise_n, both_n, per, w, bad;
        bit  ok;
        logic prev;

        tick(10);
        chk("R11 reset hs", int'(hs), 0);
        chk("R11 reset ls", int'(ls), 0);
        chk("R11 reset fault", int'(fault), 0);
        rst_n = 1'b1;
        en    = 1'b1;

        for (int i = 0; i < VEC_N; i++) begin
            sleep = V_SB[i][0];
            duty  = 9'(V_CMD[i]);
            tick(2400);
            per  = (V_SB[i] != 0) ? 400 : 800;
            hi_n = 0; lo_n = 0; both_n = 0;
            for (int c = 0; c < per; c++) begin
                @(negedge clk);
                if (hs) hi_n++;
                if (ls) lo_n++;
            end
            chk((V_SB[i] != 0) ? "R3 standby high cycles" : "R2 normal high cycles", hi_n, V_HI[i]);
            chk((V_SB[i] != 0) ? "R3 standby low cycles" : "R4 normal low cycles", lo_n, V_LO[i]);
            rise_n = 0;
            prev = hs;
            for (int c = 0; c < 3200; c++) begin
                @(negedge clk);
                if (!prev && hs) rise_n++;
                if (hs && ls) both_n++;
                prev = hs;
            end
            chk("R1 rising edges per window", rise_n, V_RISE[i]);
            chk("R4 overlap cycles", both_n, 0);
        end

        // R5: mode and duty take effect only at the next period
        sleep = 1'b0; duty = 9'd128;
        tick(2400);
        wait_rise(ok);
        sleep = 1'b1;
        pulse_width(w);
        chk("R5 pulse width after mid-period mode change", w, 396);
        wait_rise(ok);
        duty = 9'd64;
        pulse_width(w);
        chk("R5 standby pulse after mid-period duty change", w, 196);
        wait_rise(ok);
        pulse_width(w);
        chk("R5 next standby pulse uses new duty", w, 96);

        // R8: overcurrent ignored in standby
        duty = 9'd128;
        tick(1200);
        oc = 1'b1;
        rise_n = 0;
        prev = hs;
        for (int c = 0; c < 1000; c++) begin
            @(negedge clk);
            if (!prev && hs) rise_n++;
            prev = hs;
        end
        oc = 1'b0;
        chk("R8 no fault in standby", int'(fault), 0);
        chk("R8 switching continues", int'(rise_n > 0), 1);

        // R7: ignored while high side off and during blanking
        sleep = 1'b0;
        tick(2400);
        wait_fall(ok);
        oc = 1'b1;
        tick(300);
        oc = 1'b0;
        chk("R7 oc ignored while high side off", int'(fault), 0);
        wait_rise(ok);
        oc = 1'b1;
        tick(80);
        oc = 1'b0;
        chk("R7 oc ignored in blanking window", int'(fault), 0);
        chk("R7 high side still on after blanking", int'(hs), 1);
        oc = 1'b1;
        tick(1);
        oc = 1'b0;
        chk("R9 fault set one cycle after blanking", int'(fault), 1);
        chk("R9 gates off on trip", int'(hs | ls), 0);
        bad = 0;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (hs || ls || !fault) bad++;
        end
        chk("R9 fault latched with gates off", bad, 0);

        // R10: clear
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        chk("R10 fault cleared", int'(fault), 0);
        wait_rise(ok);
        chk("R10 switching resumes", int'(ok), 1);

        // R6: enable low
        tick(100);
        en = 1'b0;
        bad = 0;
        for (int c = 0; c < 1000; c++) begin
            @(negedge clk);
            if (hs || ls) bad++;
        end
        chk("R6 gates low while disabled", bad, 0);
        en = 1'b1;
        wait_rise(ok);
        chk("R6 switching after re-enable", int'(ok), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule